// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits on the device side of a parallel NOR-style flash interface. It observes synchronous write cycles, each given as an address, a data word and a one-cycle strobe. It recognises the unlock-guarded command sequences of the flash command set. Every sequence opens with two unlock writes. A third write then selects the word program path, the erase path or a mode change. The erase path needs a second pair of unlock writes and then a sixth write that picks chip, sector or block erase. A lone exit write also returns the part to plain read mode.

For each recognised command, the decoder raises a one-cycle request to the array controller. For program and erase commands it also holds the target address and data. It tracks the current read mode (array, identification or query). It also keeps a busy flag that is set when a program or erase is requested and that only the controller's done input clears. While busy, the decoder ignores the bus entirely.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, mode is 0 (array read), busy is 0 and no request output is high.
- R2: Only address bits 14..0 and data bits 7..0 take part in command matching. Other address and data bits do not change the decoding.
- R3: The writes AAh@5555h, 55h@2AAAh, A0h@5555h followed by any fourth write raise req_program for one cycle, in the cycle after the fourth strobe. tgt_addr and tgt_data then hold that write's full address and data.
- R4: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h raise req_chip_erase.
- R5: The same five-write prefix followed by 30h at any address raises req_sector_erase, with sector_sel equal to address bits 20..11 of that sixth write.
- R6: The same prefix followed by 50h at any address raises req_block_erase, with block_sel equal to address bits 20..15 of that sixth write.
- R7: Two unlock writes then 90h@5555h raise req_id_enter, and mode becomes 1 (identification).
- R8: Two unlock writes then 98h@5555h raise req_query_enter, and mode becomes 2 (query).
- R9: Exit is accepted in two forms, and both raise req_exit and set mode to 0. The first is two unlock writes then F0h@5555h. The second is a single F0h write at any address when no sequence is in progress.
- R10: A write that does not match the expected next step of a sequence in progress aborts it with no request and sets mode to 0. That write is never taken as the first step of a new sequence.
- R11: busy rises in the same cycle as a program or erase request and falls only on the clock edge that samples op_done high.
- R12: While busy is high, every write is ignored, including both exit forms. Such writes do not advance any sequence and do not change the mode.
- R13: At most one request output is high in any cycle, and each request lasts one cycle.
- R14: When no sequence is in progress, a write other than AAh@5555h or F0h leaves the mode unchanged and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W (21) | Write address |
| wr_data | input | DATA_W (16) | Write data |
| op_done | input | 1 | Array controller finished the program or erase |
| req_program | output | 1 | Word program request pulse |
| req_sector_erase | output | 1 | Sector erase request pulse |
| req_block_erase | output | 1 | Block erase request pulse |
| req_chip_erase | output | 1 | Chip erase request pulse |
| req_id_enter | output | 1 | Identification mode entered |
| req_query_enter | output | 1 | Query mode entered |
| req_exit | output | 1 | Return to array read mode |
| tgt_addr | output | ADDR_W | Address of the last program or erase target |
| tgt_data | output | DATA_W | Data of the last program target |
| sector_sel | output | ADDR_W-SECT_LSB | Sector select taken from tgt_addr |
| block_sel | output | ADDR_W-BLK_LSB | Block select taken from tgt_addr |
| mode | output | 2 | 0 array read, 1 identification, 2 query |
| busy | output | 1 | Program or erase in progress |

## Verification
The bench builds the decoder with its default widths: a 21-bit address, 16-bit data, sectors starting at bit 11 and blocks at bit 15. With these widths the address bits above the 15 compared bits exist. The bench sets them, and data bits 15..8, to nonzero values on unlock writes, so matching is shown to ignore them. The same widths yield 10-bit sector selects and 6-bit block selects, which the bench checks against targets near the top of the address space. Aborts are driven at the second, third and sixth steps. Busy is held for many cycles while complete exit and unlock sequences are written, to show that they leave no trace.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int CMP_AW = 15;
  localparam int CMP_DW = 8;

  localparam logic [CMP_AW-1:0] K_ADDR_A = 15'h5555;
  localparam logic [CMP_AW-1:0] K_ADDR_B = 15'h2AAA;

  localparam logic [CMP_DW-1:0] K_D_UNL1 = 8'hAA;
  localparam logic [CMP_DW-1:0] K_D_UNL2 = 8'h55;
  localparam logic [CMP_DW-1:0] K_D_PGM  = 8'hA0;
  localparam logic [CMP_DW-1:0] K_D_ERS  = 8'h80;
  localparam logic [CMP_DW-1:0] K_D_ID   = 8'h90;
  localparam logic [CMP_DW-1:0] K_D_QRY  = 8'h98;
  localparam logic [CMP_DW-1:0] K_D_EXIT = 8'hF0;
  localparam logic [CMP_DW-1:0] K_D_CHIP = 8'h10;
  localparam logic [CMP_DW-1:0] K_D_SECT = 8'h30;
  localparam logic [CMP_DW-1:0] K_D_BLK  = 8'h50;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_U1   = 3'd1,
    SQ_U2   = 3'd2,
    SQ_PGM  = 3'd3,
    SQ_E3   = 3'd4,
    SQ_E4   = 3'd5,
    SQ_E5   = 3'd6
  } seq_t;

  typedef enum logic [1:0] {
    MD_READ  = 2'd0,
    MD_ID    = 2'd1,
    MD_QUERY = 2'd2
  } mode_t;

  typedef struct packed {
    logic addr_a;
    logic addr_b;
    logic d_unl1;
    logic d_unl2;
    logic d_pgm;
    logic d_ers;
    logic d_id;
    logic d_qry;
    logic d_exit;
    logic d_chip;
    logic d_sect;
    logic d_blk;
  } match_t;

  typedef struct packed {
    logic prog;
    logic sect;
    logic blk;
    logic chip;
    logic id;
    logic query;
    logic leave;
  } req_t;

endpackage

// File: rtl/fcd_match.sv
module fcd_match
  import flash_cmd_pkg::*;
(
  input  logic [CMP_AW-1:0] cmp_addr,
  input  logic [CMP_DW-1:0] cmp_data,
  output match_t            hit
);

  always_comb begin
    hit.addr_a = (cmp_addr == K_ADDR_A);
    hit.addr_b = (cmp_addr == K_ADDR_B);
    hit.d_unl1 = (cmp_data == K_D_UNL1);
    hit.d_unl2 = (cmp_data == K_D_UNL2);
    hit.d_pgm  = (cmp_data == K_D_PGM);
    hit.d_ers  = (cmp_data == K_D_ERS);
    hit.d_id   = (cmp_data == K_D_ID);
    hit.d_qry  = (cmp_data == K_D_QRY);
    hit.d_exit = (cmp_data == K_D_EXIT);
    hit.d_chip = (cmp_data == K_D_CHIP);
    hit.d_sect = (cmp_data == K_D_SECT);
    hit.d_blk  = (cmp_data == K_D_BLK);
  end

endmodule

// File: rtl/fcd_sequencer.sv
module fcd_sequencer
  import flash_cmd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_stb,
  input  logic   busy,
  input  match_t hit,
  output req_t   req_nxt,
  output logic   abort_nxt,
  output req_t   req_q
);

  seq_t st_q, st_d;
  logic accept;

  assign accept = wr_stb & ~busy;

  always_comb begin
    st_d      = st_q;
    req_nxt   = '0;
    abort_nxt = 1'b0;
    if (accept) begin
      unique case (st_q)
        SQ_IDLE: begin
          if (hit.addr_a && hit.d_unl1) st_d = SQ_U1;
          else if (hit.d_exit)          req_nxt.leave = 1'b1;
        end
        SQ_U1: begin
          if (hit.addr_b && hit.d_unl2) st_d = SQ_U2;
          else begin
            st_d      = SQ_IDLE;
            abort_nxt = 1'b1;
          end
        end
        SQ_U2: begin
          st_d = SQ_IDLE;
          if (!hit.addr_a)     abort_nxt     = 1'b1;
          else if (hit.d_pgm)  st_d          = SQ_PGM;
          else if (hit.d_ers)  st_d          = SQ_E3;
          else if (hit.d_id)   req_nxt.id    = 1'b1;
          else if (hit.d_qry)  req_nxt.query = 1'b1;
          else if (hit.d_exit) req_nxt.leave = 1'b1;
          else                 abort_nxt     = 1'b1;
        end
        SQ_PGM: begin
          st_d         = SQ_IDLE;
          req_nxt.prog = 1'b1;
        end
        SQ_E3: begin
          if (hit.addr_a && hit.d_unl1) st_d = SQ_E4;
          else begin
            st_d      = SQ_IDLE;
            abort_nxt = 1'b1;
          end
        end
        SQ_E4: begin
          if (hit.addr_b && hit.d_unl2) st_d = SQ_E5;
          else begin
            st_d      = SQ_IDLE;
            abort_nxt = 1'b1;
          end
        end
        SQ_E5: begin
          st_d = SQ_IDLE;
          if (hit.d_chip && hit.addr_a) req_nxt.chip = 1'b1;
          else if (hit.d_sect)          req_nxt.sect = 1'b1;
          else if (hit.d_blk)           req_nxt.blk  = 1'b1;
          else                          abort_nxt    = 1'b1;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      req_q <= '0;
    end else begin
      st_q  <= st_d;
      req_q <= req_nxt;
    end
  end

endmodule

// File: rtl/fcd_tracker.sv
module fcd_tracker
  import flash_cmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  req_t  req_nxt,
  input  logic  abort_nxt,
  input  logic  op_done,
  output mode_t mode_q,
  output logic  busy_q
);

  mode_t mode_d;
  logic  mode_en;
  logic  busy_d;
  logic  busy_en;
  logic  issue;

  assign issue = req_nxt.prog | req_nxt.sect | req_nxt.blk | req_nxt.chip;

  always_comb begin
    mode_en = abort_nxt | req_nxt.leave | req_nxt.id | req_nxt.query;
    if (req_nxt.id)         mode_d = MD_ID;
    else if (req_nxt.query) mode_d = MD_QUERY;
    else                    mode_d = MD_READ;
  end

  always_comb begin
    busy_en = issue | op_done;
    busy_d  = issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_READ;
      busy_q <= 1'b0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (busy_en) busy_q <= busy_d;
    end
  end

endmodule

// File: rtl/fcd_target.sv
module fcd_target #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_addr <= '0;
      tgt_data <= '0;
    end else if (capture) begin
      tgt_addr <= wr_addr;
      tgt_data <= wr_data;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_stb,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       op_done,
  output logic                       req_program,
  output logic                       req_sector_erase,
  output logic                       req_block_erase,
  output logic                       req_chip_erase,
  output logic                       req_id_enter,
  output logic                       req_query_enter,
  output logic                       req_exit,
  output logic [ADDR_W-1:0]          tgt_addr,
  output logic [DATA_W-1:0]          tgt_data,
  output logic [ADDR_W-SECT_LSB-1:0] sector_sel,
  output logic [ADDR_W-BLK_LSB-1:0]  block_sel,
  output logic [1:0]                 mode,
  output logic                       busy
);

  localparam int SECT_W = ADDR_W - SECT_LSB;
  localparam int BLK_W  = ADDR_W - BLK_LSB;

  match_t hit;
  req_t   req_nxt;
  req_t   req_q;
  logic   abort_nxt;
  mode_t  mode_q;
  logic   busy_q;
  logic   capture;

  fcd_match u_match (
    .cmp_addr (wr_addr[CMP_AW-1:0]),
    .cmp_data (wr_data[CMP_DW-1:0]),
    .hit      (hit)
  );

  fcd_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .busy      (busy_q),
    .hit       (hit),
    .req_nxt   (req_nxt),
    .abort_nxt (abort_nxt),
    .req_q     (req_q)
  );

  fcd_tracker u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_nxt   (req_nxt),
    .abort_nxt (abort_nxt),
    .op_done   (op_done),
    .mode_q    (mode_q),
    .busy_q    (busy_q)
  );

  assign capture = req_nxt.prog | req_nxt.sect | req_nxt.blk | req_nxt.chip;

  fcd_target #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_tgt (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .tgt_addr (tgt_addr),
    .tgt_data (tgt_data)
  );

  assign sector_sel       = tgt_addr[SECT_LSB +: SECT_W];
  assign block_sel        = tgt_addr[BLK_LSB +: BLK_W];
  assign req_program      = req_q.prog;
  assign req_sector_erase = req_q.sect;
  assign req_block_erase  = req_q.blk;
  assign req_chip_erase   = req_q.chip;
  assign req_id_enter     = req_q.id;
  assign req_query_enter  = req_q.query;
  assign req_exit         = req_q.leave;
  assign mode             = mode_q;
  assign busy             = busy_q;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stb,
  input logic       op_done,
  input logic       req_program,
  input logic       req_sector_erase,
  input logic       req_block_erase,
  input logic       req_chip_erase,
  input logic       req_id_enter,
  input logic       req_query_enter,
  input logic       req_exit,
  input logic [1:0] mode,
  input logic       busy
);

  logic any_req;
  logic any_op;
  assign any_op  = req_program | req_sector_erase | req_block_erase | req_chip_erase;
  assign any_req = any_op | req_id_enter | req_query_enter | req_exit;

  // R13
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_program, req_sector_erase, req_block_erase, req_chip_erase,
              req_id_enter, req_query_enter, req_exit}));

  // R13
  prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_program |=> !req_program);

  // R3
  prog_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_program |-> $past(wr_stb));

  // R11
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> any_op);

  // R11
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(op_done));

  // R12
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !any_req);

  // R7
  id_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_id_enter |-> (mode == 2'd1));

  // R8
  query_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_query_enter |-> (mode == 2'd2));

  // R9
  exit_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_exit |-> (mode == 2'd0));

endmodule

bind flash_cmd_decoder fcd_checker u_fcd_checker (
  .clk              (clk),
  .rst_n            (rst_n),
  .wr_stb           (wr_stb),
  .op_done          (op_done),
  .req_program      (req_program),
  .req_sector_erase (req_sector_erase),
  .req_block_erase  (req_block_erase),
  .req_chip_erase   (req_chip_erase),
  .req_id_enter     (req_id_enter),
  .req_query_enter  (req_query_enter),
  .req_exit         (req_exit),
  .mode             (mode),
  .busy             (busy)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;

  localparam int AW = 21;
  localparam int DW = 16;

  logic          clk;
  logic          rst_n;
  logic          wr_stb;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          op_done;
  logic          req_program, req_sector_erase, req_block_erase, req_chip_erase;
  logic          req_id_enter, req_query_enter, req_exit;
  logic [AW-1:0] tgt_addr;
  logic [DW-1:0] tgt_data;
  logic [9:0]    sector_sel;
  logic [5:0]    block_sel;
  logic [1:0]    mode;
  logic          busy;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .op_done(op_done),
    .req_program(req_program), .req_sector_erase(req_sector_erase),
    .req_block_erase(req_block_erase), .req_chip_erase(req_chip_erase),
    .req_id_enter(req_id_enter), .req_query_enter(req_query_enter),
    .req_exit(req_exit), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
    .sector_sel(sector_sel), .block_sel(block_sel), .mode(mode), .busy(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // kinds: 1 program, 2 sector, 3 block, 4 chip, 5 id, 6 query, 7 exit
  typedef struct {
    int          kind;
    logic [31:0] va;
    logic [31:0] vb;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(int kind, logic [31:0] va, logic [31:0] vb, string tag);
    item_t it;
    it.kind = kind; it.va = va; it.vb = vb; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor: pops expected items as requests appear
  always @(negedge clk) begin
    if (rst_n) begin
      int cnt;
      int kind;
      logic [31:0] va, vb;
      cnt = 0; kind = 0; va = '0; vb = '0;
      if (req_program)      begin cnt++; kind = 1; va = 32'(tgt_addr);   vb = 32'(tgt_data); end
      if (req_sector_erase) begin cnt++; kind = 2; va = 32'(sector_sel); end
      if (req_block_erase)  begin cnt++; kind = 3; va = 32'(block_sel);  end
      if (req_chip_erase)   begin cnt++; kind = 4; end
      if (req_id_enter)     begin cnt++; kind = 5; end
      if (req_query_enter)  begin cnt++; kind = 6; end
      if (req_exit)         begin cnt++; kind = 7; end
      if (cnt > 1) chk("R13 one request per cycle", 32'(cnt), 32'd1);
      if (cnt != 0) begin
        if (exp_q.size() == 0) begin
          chk("R12/R10/R14 unexpected request", 32'(kind), 32'd0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk({it.tag, " kind"}, 32'(kind), 32'(it.kind));
          chk({it.tag, " value a"}, va, it.va);
          chk({it.tag, " value b"}, vb, it.vb);
        end
      end
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  // unlock pair with junk in the don't-care bits (R2)
  task automatic unl();
    wr(21'h1D5555, 16'hC3AA);
    wr(21'h0AAAAA, 16'h7E55);
  endtask

  task automatic drained(string tag);
    repeat (2) @(negedge clk);
    chk({tag, " queue drained"}, 32'(exp_q.size()), 32'd0);
  endtask

  task automatic finish_op();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
    chk("R11 busy cleared by op_done", 32'(busy), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; wr_stb = 1'b0; wr_addr = '0; wr_data = '0; op_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 mode", 32'(mode), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 requests", 32'({req_program, req_sector_erase, req_block_erase,
        req_chip_erase, req_id_enter, req_query_enter, req_exit}), 32'd0);

    // R14 stray write in idle
    wr(21'h001234, 16'h0012);
    drained("R14 stray write");
    chk("R14 mode", 32'(mode), 32'd0);

    // R7 id entry
    push(5, 0, 0, "R7 id entry");
    unl(); wr(21'h155555, 16'hFF90);
    chk("R7 mode", 32'(mode), 32'd1);
    // R14 stray write leaves id mode
    wr(21'h000100, 16'h0033);
    chk("R14 mode kept", 32'(mode), 32'd1);

    // R9 single F0 at arbitrary address
    push(7, 0, 0, "R9 short exit");
    wr(21'h010ABC, 16'h12F0);
    chk("R9 short exit mode", 32'(mode), 32'd0);

    // R8 query entry, then R9 full exit
    push(6, 0, 0, "R8 query entry");
    unl(); wr(21'h0D5555, 16'h0198);
    chk("R8 mode", 32'(mode), 32'd2);
    push(7, 0, 0, "R9 full exit");
    unl(); wr(21'h1F5555, 16'hAAF0);
    chk("R9 full exit mode", 32'(mode), 32'd0);
    drained("R7 R8 R9");

    // R3 program
    push(1, 32'h1FABCD, 32'h3C5A, "R3 program");
    unl(); wr(21'h005555, 16'h00A0);
    wr(21'h1FABCD, 16'h3C5A);
    chk("R11 busy set with request", 32'(busy), 32'd1);
    repeat (20) @(negedge clk);
    chk("R11 busy held without op_done", 32'(busy), 32'd1);

    // R12 everything ignored while busy
    wr(21'h000000, 16'h00F0);
    unl(); wr(21'h005555, 16'h00F0);
    unl(); wr(21'h005555, 16'h0090);
    unl();
    chk("R12 mode untouched", 32'(mode), 32'd0);
    chk("R12 still busy", 32'(busy), 32'd1);
    finish_op();
    wr(21'h005555, 16'h0090);
    chk("R12 sequence not advanced", 32'(mode), 32'd0);
    drained("R3 R12");

    // R4 chip erase
    push(4, 0, 0, "R4 chip erase");
    unl(); wr(21'h005555, 16'h0080); unl(); wr(21'h1C5555, 16'hEE10);
    chk("R11 busy after chip erase", 32'(busy), 32'd1);
    finish_op();

    // R5 sector erase
    push(2, (32'h1A5FFF >> 11) & 32'h3FF, 0, "R5 sector erase");
    unl(); wr(21'h005555, 16'h0080); unl(); wr(21'h1A5FFF, 16'h0030);
    finish_op();

    // R6 block erase
    push(3, (32'h17_8001 >> 15) & 32'h3F, 0, "R6 block erase");
    unl(); wr(21'h005555, 16'h0080); unl(); wr(21'h178001, 16'h0050);
    finish_op();
    drained("R4 R5 R6");

    // R10 abort at step two returns to read mode
    push(5, 0, 0, "R10 setup id");
    unl(); wr(21'h005555, 16'h0090);
    wr(21'h005555, 16'h00AA); wr(21'h002AAA, 16'h0012);
    chk("R10 abort to read", 32'(mode), 32'd0);
    // R10 offending AA not a fresh start
    wr(21'h005555, 16'h00AA); wr(21'h005555, 16'h00AA);
    wr(21'h002AAA, 16'h0055); wr(21'h005555, 16'h0090);
    chk("R10 no restart", 32'(mode), 32'd0);
    // R10 chip code at wrong address aborts
    unl(); wr(21'h005555, 16'h0080); unl(); wr(21'h001234, 16'h0010);
    chk("R10 no busy after abort", 32'(busy), 32'd0);
    // R10 wrong third step aborts
    unl(); wr(21'h002AAA, 16'h0090);
    chk("R10 third step abort", 32'(mode), 32'd0);
    drained("R10");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule